// File: doc/BRIEF.md
# Dual Smart Card Clock Divider

This block produces two card clock outputs from two free-running input clocks. Each card has its own divider with ratios from 1 to 8. Both phases of the output clock last the same number of input half-periods, so the duty cycle is 50% for odd ratios as well as even ones. A per-card routing bit chooses which input clock feeds that card's divider, so either input can drive either card.

A host writes a 5-bit control word into one card through a strobe interface. A write is accepted only while both the active-low program-enable and the active-low chip-select are asserted. The new settings are held as pending. They move into the live divider only where a low phase ends, so the output never shows a shortened pulse. A per-card busy flag is high while settings are pending, which lets software wait before it starts a card transaction. A stop bit parks the output low at a phase boundary.

All logic runs on one system clock. The input clocks are synchronised into that domain, and each transition of the selected input counts as one divider event. The system clock has to run several times faster than either input clock.

Top module: `sccd_top`

## Requirements
- R1: While `rst` is high, both card clocks and both busy flags are low. After reset each card runs at ratio 1:1 with straight routing (card A from input A, card B from input B) and is not stopped.
- R2: A ratio field value v (0..7) divides the selected input by v+1. The high phase and the low phase each last exactly v+1 input half-periods, odd ratios included.
- R3: With route bit 0 a card takes its own input (A from A, B from B). With route bit 1 it takes the other input.
- R4: A write is accepted only when `wr_stb` is high and both `prog_n` and `cs_n` are low. Any other write attempt changes neither output timing nor busy.
- R5: The write word `wr_data` holds the ratio field in bits [2:0], the route bit in bit 3 and the stop bit in bit 4. `card_sel` 0 addresses card A and 1 addresses card B.
- R6: A card's busy flag is high in the cycle after an accepted write to that card. It stays high until the pending settings are applied.
- R7: Pending settings are applied only when a low phase ends. Every output high pulse is a full pulse of either the old or the new ratio, never a shortened one.
- R8: Pending settings are applied within 8 periods of the previously selected input clock, plus a small synchroniser latency.
- R9: With the stop bit set, the output stays low from the end of its current cycle onward. After a write with the stop bit cleared, the output resumes with a full-width high pulse.
- R10: Reprogramming one card does not change the pulse widths of the other card.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, several times faster than the input clocks |
| rst | input | 1 | Synchronous active-high reset |
| clk_in_a | input | 1 | Input clock A (asynchronous) |
| clk_in_b | input | 1 | Input clock B (asynchronous) |
| prog_n | input | 1 | Program enable, active low |
| cs_n | input | 1 | Chip select, active low |
| wr_stb | input | 1 | Write strobe, one system cycle per write |
| card_sel | input | 1 | Target card: 0 = A, 1 = B |
| wr_data | input | 5 | {stop, route, ratio[2:0]} |
| card_clk_a | output | 1 | Card A clock |
| card_clk_b | output | 1 | Card B clock |
| busy_a | output | 1 | Card A settings pending |
| busy_b | output | 1 | Card B settings pending |

## Verification
A wrong event counter or a wrong live ratio shows up as a high or low phase of the wrong length within a single output period, at most 16 input half-periods. A wrong route shows up as widths scaled by the other input's half-period. If the pending latch does not clear, busy stays high beyond the 8-period bound. If settings are applied at the wrong moment, one high pulse has a length that matches neither the old nor the new ratio, and it appears right at the switch.

// File: rtl/sccd_pkg.sv
package sccd_pkg;
    localparam int NUM_CARDS = 2;
    localparam int NUM_INPUTS = 2;
    localparam int RATIO_W = 3;
    localparam int WORD_W = RATIO_W + 2;

    typedef struct packed {
        logic               stop;
        logic               route;
        logic [RATIO_W-1:0] ratio;
    } card_cfg_t;

    typedef enum logic {
        CARD_A = 1'b0,
        CARD_B = 1'b1
    } card_id_e;

    // Which input index a card listens to for a given route bit
    function automatic logic pick_input(input logic card_idx, input logic route);
        return card_idx ^ route;
    endfunction

    function automatic card_cfg_t unpack_word(input logic [WORD_W-1:0] w);
        card_cfg_t c;
        c.ratio = w[RATIO_W-1:0];
        c.route = w[RATIO_W];
        c.stop  = w[RATIO_W+1];
        return c;
    endfunction
endpackage

// File: rtl/sccd_edge_sync.sv
module sccd_edge_sync #(
    parameter int N_IN   = 2,
    parameter int STAGES = 2
) (
    input  logic            clk,
    input  logic            rst,
    input  logic [N_IN-1:0] raw_in,
    output logic [N_IN-1:0] edge_evt
);
    localparam int LAST = STAGES - 1;

    for (genvar i = 0; i < N_IN; i++) begin : g_in
        logic [STAGES-1:0] sync_q;
        logic              prev_q;

        always_ff @(posedge clk) begin
            if (rst) begin
                sync_q <= '0;
                prev_q <= 1'b0;
            end else begin
                sync_q <= {sync_q[STAGES-2:0], raw_in[i]};
                prev_q <= sync_q[LAST];
            end
        end

        // Every transition (rising or falling) is one half-period event
        assign edge_evt[i] = sync_q[LAST] ^ prev_q;
    end
endmodule

// File: rtl/sccd_host_if.sv
module sccd_host_if
    import sccd_pkg::*;
(
    input  logic                 wr_stb,
    input  logic                 prog_n,
    input  logic                 cs_n,
    input  logic                 card_sel,
    input  logic [WORD_W-1:0]    wr_data,
    output logic [NUM_CARDS-1:0] wr_en,
    output card_cfg_t            wr_cfg
);
    logic accept;

    assign accept = wr_stb && !prog_n && !cs_n;
    assign wr_cfg = unpack_word(wr_data);

    for (genvar c = 0; c < NUM_CARDS; c++) begin : g_dec
        assign wr_en[c] = accept && (card_sel == c[0]);
    end
endmodule

// File: rtl/sccd_divider.sv
module sccd_divider
    import sccd_pkg::*;
#(
    parameter logic CARD_IDX = 1'b0
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic [NUM_INPUTS-1:0] edge_evt,
    input  logic                  wr_en,
    input  card_cfg_t             wr_cfg,
    output logic                  card_clk,
    output logic                  busy
);
    logic [RATIO_W-1:0] live_ratio;
    logic               live_route;
    logic [RATIO_W-1:0] next_ratio;
    logic               next_route;
    logic               pending;
    logic               stop_q;
    logic [RATIO_W-1:0] cnt;
    logic               out_q;
    logic               evt;
    logic               phase_end;

    assign evt       = edge_evt[pick_input(CARD_IDX, live_route)];
    assign phase_end = evt && (cnt == live_ratio);

    always_ff @(posedge clk) begin
        if (rst) begin
            live_ratio <= '0;
            live_route <= 1'b0;
            next_ratio <= '0;
            next_route <= 1'b0;
            pending    <= 1'b0;
            stop_q     <= 1'b0;
            cnt        <= '0;
            out_q      <= 1'b0;
        end else begin
            if (evt) begin
                if (phase_end) begin
                    cnt <= '0;
                    if (out_q) begin
                        out_q <= 1'b0;
                    end else begin
                        // End of low phase: the only safe switch point
                        if (pending) begin
                            live_ratio <= next_ratio;
                            live_route <= next_route;
                            pending    <= 1'b0;
                        end
                        out_q <= !stop_q;
                    end
                end else begin
                    cnt <= cnt + RATIO_W'(1);
                end
            end
            if (wr_en) begin
                next_ratio <= wr_cfg.ratio;
                next_route <= wr_cfg.route;
                stop_q     <= wr_cfg.stop;
                pending    <= 1'b1;
            end
        end
    end

    assign card_clk = out_q;
    assign busy     = pending;
endmodule

// File: rtl/sccd_top.sv
module sccd_top
    import sccd_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              clk_in_a,
    input  logic              clk_in_b,
    input  logic              prog_n,
    input  logic              cs_n,
    input  logic              wr_stb,
    input  logic              card_sel,
    input  logic [WORD_W-1:0] wr_data,
    output logic              card_clk_a,
    output logic              card_clk_b,
    output logic              busy_a,
    output logic              busy_b
);
    logic [NUM_INPUTS-1:0] edge_evt;
    logic [NUM_CARDS-1:0]  wr_en;
    card_cfg_t             wr_cfg;
    logic [NUM_CARDS-1:0]  clk_vec;
    logic [NUM_CARDS-1:0]  busy_vec;

    sccd_edge_sync #(.N_IN(NUM_INPUTS), .STAGES(2)) u_sync (
        .clk      (clk),
        .rst      (rst),
        .raw_in   ({clk_in_b, clk_in_a}),
        .edge_evt (edge_evt)
    );

    sccd_host_if u_host (
        .wr_stb   (wr_stb),
        .prog_n   (prog_n),
        .cs_n     (cs_n),
        .card_sel (card_sel),
        .wr_data  (wr_data),
        .wr_en    (wr_en),
        .wr_cfg   (wr_cfg)
    );

    for (genvar c = 0; c < NUM_CARDS; c++) begin : g_card
        sccd_divider #(.CARD_IDX(c[0])) u_div (
            .clk      (clk),
            .rst      (rst),
            .edge_evt (edge_evt),
            .wr_en    (wr_en[c]),
            .wr_cfg   (wr_cfg),
            .card_clk (clk_vec[c]),
            .busy     (busy_vec[c])
        );
    end

    assign card_clk_a = clk_vec[CARD_A];
    assign card_clk_b = clk_vec[CARD_B];
    assign busy_a     = busy_vec[CARD_A];
    assign busy_b     = busy_vec[CARD_B];
endmodule

// File: rtl/sccd_checker.sv
module sccd_checker (
    input logic clk,
    input logic rst,
    input logic prog_n,
    input logic cs_n,
    input logic wr_stb,
    input logic card_sel,
    input logic card_clk_a,
    input logic card_clk_b,
    input logic busy_a,
    input logic busy_b
);
    logic acc_a;
    logic acc_b;
    assign acc_a = wr_stb && !prog_n && !cs_n && !card_sel;
    assign acc_b = wr_stb && !prog_n && !cs_n && card_sel;

    p_reset_low_r1: assert property (@(posedge clk)
        rst |=> (!card_clk_a && !card_clk_b && !busy_a && !busy_b));

    p_busy_set_a_r6: assert property (@(posedge clk) disable iff (rst)
        acc_a |=> busy_a);
    p_busy_set_b_r6: assert property (@(posedge clk) disable iff (rst)
        acc_b |=> busy_b);

    p_ignore_a_r4: assert property (@(posedge clk) disable iff (rst)
        (!acc_a && !busy_a) |=> !busy_a);
    p_ignore_b_r4: assert property (@(posedge clk) disable iff (rst)
        (!acc_b && !busy_b) |=> !busy_b);

    p_apply_low_a_r7: assert property (@(posedge clk) disable iff (rst)
        $fell(busy_a) |-> $past(!card_clk_a));
    p_apply_low_b_r7: assert property (@(posedge clk) disable iff (rst)
        $fell(busy_b) |-> $past(!card_clk_b));
endmodule

bind sccd_top sccd_checker u_chk (
    .clk        (clk),
    .rst        (rst),
    .prog_n     (prog_n),
    .cs_n       (cs_n),
    .wr_stb     (wr_stb),
    .card_sel   (card_sel),
    .card_clk_a (card_clk_a),
    .card_clk_b (card_clk_b),
    .busy_a     (busy_a),
    .busy_b     (busy_b)
);

// File: tb/sim_sccd_top.sv
module sim_sccd_top;
    localparam int HA = 3;
    localparam int HB = 5;
    localparam int WDOG = 150000;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic clk_in_a = 1'b0;
    logic clk_in_b = 1'b0;
    logic prog_n = 1'b1;
    logic cs_n = 1'b1;
    logic wr_stb = 1'b0;
    logic card_sel = 1'b0;
    logic [4:0] wr_data = '0;
    logic card_clk_a, card_clk_b, busy_a, busy_b;

    int n_checks = 0;
    int n_fail = 0;
    int cyc = 0;
    bit done = 0;

    typedef struct {
        int    card;
        int    hi;
        int    lo;
        string tag;
    } exp_t;
    exp_t sb[$];

    sccd_top u0 (
        .clk(clk), .rst(rst), .clk_in_a(clk_in_a), .clk_in_b(clk_in_b),
        .prog_n(prog_n), .cs_n(cs_n), .wr_stb(wr_stb), .card_sel(card_sel),
        .wr_data(wr_data), .card_clk_a(card_clk_a), .card_clk_b(card_clk_b),
        .busy_a(busy_a), .busy_b(busy_b)
    );

    always #2 clk = ~clk;

    initial forever begin
        repeat (HA) @(negedge clk);
        clk_in_a = ~clk_in_a;
    end
    initial forever begin
        repeat (HB) @(negedge clk);
        clk_in_b = ~clk_in_b;
    end

    function automatic logic cclk(input int card);
        return (card == 0) ? card_clk_a : card_clk_b;
    endfunction
    function automatic logic cbusy(input int card);
        return (card == 0) ? busy_a : busy_b;
    endfunction

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic measure(input int card, output int hi, output int lo);
        while (cclk(card)) @(negedge clk);
        while (!cclk(card)) @(negedge clk);
        hi = 0;
        while (cclk(card)) begin hi++; @(negedge clk); end
        lo = 0;
        while (!cclk(card)) begin lo++; @(negedge clk); end
    endtask

    // Scoreboard monitor
    initial forever begin
        @(negedge clk);
        if (sb.size() != 0) begin
            int h, l;
            exp_t e;
            e = sb[0];
            measure(e.card, h, l);
            check(h == e.hi, {e.tag, " high"}, h, e.hi);
            check(l == e.lo, {e.tag, " low"}, l, e.lo);
            void'(sb.pop_front());
        end
    end

    task automatic expect_pulse(input int card, input int w, input string tag);
        exp_t e;
        e.card = card; e.hi = w; e.lo = w; e.tag = tag;
        sb.push_back(e);
        while (sb.size() != 0) @(negedge clk);
    endtask

    task automatic write(input int card, input bit stop, input bit route,
                         input int ratio, input bit pn, input bit cn);
        @(negedge clk);
        prog_n = pn; cs_n = cn; wr_stb = 1'b1;
        card_sel = card[0];
        wr_data = {stop, route, 3'(ratio)};
        @(negedge clk);
        wr_stb = 1'b0; prog_n = 1'b1; cs_n = 1'b1;
    endtask

    task automatic wait_idle(input int card, output int waited);
        waited = 0;
        while (cbusy(card)) begin waited++; @(negedge clk); end
    endtask

    always @(posedge clk) begin
        cyc++;
        if (cyc > WDOG && !done) begin
            n_checks++; n_fail++;
            $display("FAIL watchdog actual=%0d expected=%0d", cyc, WDOG);
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    end

    initial begin
        int w, h, l;
        int lo_ok;
        repeat (6) @(negedge clk);
        // R1: reset state
        check(!card_clk_a && !card_clk_b, "R1 clocks low in reset", card_clk_a + card_clk_b, 0);
        check(!busy_a && !busy_b, "R1 busy low in reset", busy_a + busy_b, 0);
        rst = 1'b0;
        repeat (4) @(negedge clk);

        // R1/R3: defaults 1:1 straight
        expect_pulse(0, HA, "R1 default card A");
        expect_pulse(1, HB, "R1 default card B");

        // R2/R5/R6: odd ratio 3 on card A
        write(0, 0, 0, 2, 0, 0);
        check(busy_a == 1'b1, "R6 busy after write", busy_a, 1);
        wait_idle(0, w);
        expect_pulse(0, 3 * HA, "R2 ratio 3 card A");
        // R10: card B untouched
        expect_pulse(1, HB, "R10 card B unchanged");

        // R2: ratios 8, 5, 2, 7
        write(0, 0, 0, 7, 0, 0); wait_idle(0, w);
        expect_pulse(0, 8 * HA, "R2 ratio 8 card A");
        write(0, 0, 0, 4, 0, 0); wait_idle(0, w);
        expect_pulse(0, 5 * HA, "R2 ratio 5 card A");
        write(1, 0, 0, 1, 0, 0); wait_idle(1, w);
        expect_pulse(1, 2 * HB, "R2 ratio 2 card B");
        write(1, 0, 0, 6, 0, 0); wait_idle(1, w);
        expect_pulse(1, 7 * HB, "R2 ratio 7 card B");

        // R4: gated writes ignored
        write(0, 0, 0, 0, 1, 0);
        check(busy_a == 1'b0, "R4 prog_n high ignored busy", busy_a, 0);
        expect_pulse(0, 5 * HA, "R4 prog_n high ignored width");
        write(0, 0, 0, 0, 0, 1);
        check(busy_a == 1'b0, "R4 cs_n high ignored busy", busy_a, 0);
        expect_pulse(0, 5 * HA, "R4 cs_n high ignored width");

        // R3: crossed routing
        write(0, 0, 1, 1, 0, 0); wait_idle(0, w);
        expect_pulse(0, 2 * HB, "R3 card A from input B");
        write(1, 0, 1, 2, 0, 0); wait_idle(1, w);
        expect_pulse(1, 3 * HA, "R3 card B from input A");

        // R8: worst-case ratio 8 to ratio 1 on card A (input B)
        write(0, 0, 1, 7, 0, 0); wait_idle(0, w);
        write(0, 0, 0, 0, 0, 0);
        wait_idle(0, w);
        check(w <= 16 * HB + 8, "R8 apply latency", w, 16 * HB + 8);
        expect_pulse(0, HA, "R8 new ratio in force");

        // R7: every high pulse is old or new width around the switch
        write(0, 0, 0, 1, 0, 0); wait_idle(0, w);
        write(0, 0, 0, 6, 0, 0);
        for (int k = 0; k < 3; k++) begin
            measure(0, h, l);
            check(h == 2 * HA || h == 7 * HA, "R7 no runt pulse", h, 7 * HA);
        end
        check(h == 7 * HA, "R7 settles to new ratio", h, 7 * HA);

        // R9: stop parks low, release resumes full width
        write(0, 1, 0, 1, 0, 0); wait_idle(0, w);
        while (card_clk_a) @(negedge clk);
        lo_ok = 1;
        for (int k = 0; k < 120; k++) begin
            if (card_clk_a) lo_ok = 0;
            @(negedge clk);
        end
        check(lo_ok == 1, "R9 stopped output stays low", lo_ok, 1);
        write(0, 0, 0, 1, 0, 0); wait_idle(0, w);
        expect_pulse(0, 2 * HA, "R9 resumed full width");
        expect_pulse(1, 3 * HA, "R10 card B steady through card A stop");

        done = 1;
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end
endmodule